// File: doc/BRIEF.md
# LIN Physical-Layer Controller with Wakeup Filter

This block is the digital control for a LIN transceiver. In normal mode it passes the transmit data from the protocol controller to the bus driver and returns the received bus level to the controller. A supply undervoltage flag forces the driver recessive. A dominant time-out guards the driver against a transmit pin stuck low. Once the time-out fires it stays latched until software clears it with a read-and-clear.

In standby and sleep the transmit pin is ignored. The receive output turns into an interrupt request line. It stays high until the wakeup filter accepts a wakeup, and it then stays low until the wake status is cleared. A wakeup needs a dominant level that lasts for the wake time and then returns to recessive, so a bus that is stuck dominant never wakes the device. The received bus level passes through a synchroniser before it reaches the filter. A prescaler divides the clock into the ticks that both timers count. The slope-select configuration bit is registered and passed on to the analog slew shaping.

Top module: `lin_phy_ctrl`

## Requirements
- R1: In normal mode (`mode_i` = 0), `bus_drv_o` equals `txd_i` one clock later. `rxd_o` equals `bus_rx_i` three clocks later (two synchroniser stages and an output register). On all bus signals 1 means recessive and 0 means dominant.
- R2: While `vs_uv_i` is 1, `bus_drv_o` is 1 on the next clock, whatever the level of `txd_i`.
- R3: In the low-power modes (`mode_i` = 1 standby, 2 sleep, 3 treated as sleep), `txd_i` is ignored and `bus_drv_o` is 1. Until a wakeup is latched, `rxd_o` is 1.
- R4: In a low-power mode with wakeup enabled, a dominant level that lasts at least WAKE_TICKS prescaler ticks and then returns to recessive sets `stat_wake_o`. `rxd_o` is then 0 while the mode stays low-power.
- R5: A dominant pulse that spans fewer than WAKE_TICKS ticks restarts the wake count when it ends and produces no wakeup.
- R6: A level that stays dominant, however long, does not set `stat_wake_o` until it returns to recessive.
- R7: When `cfg_wake_en_i` is 0, no bus activity sets `stat_wake_o`. After reset the enable is expected at 1.
- R8: In normal mode with `cfg_to_en_i` at 1, a `txd_i` low level that spans TO_TICKS ticks sets `stat_to_o`. `bus_drv_o` is then forced to 1.
- R9: After a time-out, `bus_drv_o` stays 1 in normal mode until a pulse on `clr_to_i` clears `stat_to_o`. After that, `txd_i` drives the bus again.
- R10: When `cfg_to_en_i` is 0, a `txd_i` low level of any length never sets `stat_to_o`, and the bus stays dominant.
- R11: `slope_low_o` follows `cfg_slope_low_i` one clock later and is 0 (normal slope) after reset.
- R12: A pulse on `clr_wake_i` clears `stat_wake_o` and returns `rxd_o` to 1. In normal mode `rxd_o` follows the bus even while `stat_wake_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Device mode: 0 normal, 1 standby, 2 sleep, 3 sleep |
| txd_i | input | 1 | Transmit data from the protocol controller (0 dominant) |
| bus_rx_i | input | 1 | Received bus level, asynchronous (0 dominant) |
| vs_uv_i | input | 1 | Supply undervoltage flag |
| cfg_wake_en_i | input | 1 | Wakeup detection enable |
| cfg_to_en_i | input | 1 | Dominant time-out enable |
| cfg_slope_low_i | input | 1 | Low slope select |
| clr_wake_i | input | 1 | Read-and-clear pulse for the wake status |
| clr_to_i | input | 1 | Read-and-clear pulse for the time-out status |
| bus_drv_o | output | 1 | Bus driver level (0 dominant) |
| rxd_o | output | 1 | Receive data, or interrupt request in low-power modes |
| slope_low_o | output | 1 | Slope select to the analog slew shaping |
| stat_wake_o | output | 1 | Latched wakeup status |
| stat_to_o | output | 1 | Latched time-out status |

## Verification
The bench builds the block with PRESCALE = 3, WAKE_TICKS = 5 and TO_TICKS = 4. With these values each timer boundary can be reached within a few dozen clocks. Any run of L·PRESCALE consecutive clocks holds exactly L ticks, whatever the prescaler phase. The bench uses this to sweep dominant lengths in whole ticks from one up to two ticks past each terminal count. It checks each length against the threshold and alternates the starting phase of the prescaler.

// File: rtl/lin_ctrl_pkg.sv
package lin_ctrl_pkg;

  typedef enum logic [1:0] {
    LM_NORMAL  = 2'd0,
    LM_STANDBY = 2'd1,
    LM_SLEEP   = 2'd2,
    LM_DEEP    = 2'd3
  } lin_mode_e;

  // Any mode other than normal is a low-power listening mode.
  function automatic logic is_low_power(input logic [1:0] m);
    return m != LM_NORMAL;
  endfunction

endpackage

// File: rtl/lin_tick_gen.sv
module lin_tick_gen #(
  parameter int PRESCALE = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (PRESCALE < 2) ? 1 : $clog2(PRESCALE);
  localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (cnt_q == P_LAST) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == P_LAST);
endmodule

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b1;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
  parameter int WAKE_TICKS = 90
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic enable_i,
  input  logic rx_i,
  output logic wake_o
);
  localparam int WW = $clog2(WAKE_TICKS + 1);
  localparam logic [WW-1:0] W_DONE = WW'(WAKE_TICKS);

  logic [WW-1:0] cnt_q;
  logic          armed;

  assign armed = (cnt_q == W_DONE);

  always_ff @(posedge clk) begin
    if (rst || !enable_i || rx_i)           cnt_q <= '0;
    else if (tick_i && !armed)              cnt_q <= cnt_q + 1'b1;
  end

  // Accept only the return to recessive after a long enough dominant level.
  assign wake_o = enable_i && rx_i && armed;
endmodule

// File: rtl/lin_dom_timeout.sv
module lin_dom_timeout #(
  parameter int TO_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic enable_i,
  input  logic txd_i,
  input  logic blocked_i,
  output logic fire_o
);
  localparam int TW = $clog2(TO_TICKS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TO_TICKS - 1);

  logic [TW-1:0] cnt_q;
  logic          counting;

  assign counting = enable_i && !txd_i && !blocked_i;

  always_ff @(posedge clk) begin
    if (rst || !counting)  cnt_q <= '0;
    else if (tick_i)       cnt_q <= cnt_q + 1'b1;
  end

  assign fire_o = counting && tick_i && (cnt_q == T_LAST);
endmodule

// File: rtl/lin_phy_ctrl.sv
module lin_phy_ctrl
  import lin_ctrl_pkg::*;
#(
  parameter int PRESCALE    = 50000,
  parameter int WAKE_TICKS  = 90,
  parameter int TO_TICKS    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       txd_i,
  input  logic       bus_rx_i,
  input  logic       vs_uv_i,
  input  logic       cfg_wake_en_i,
  input  logic       cfg_to_en_i,
  input  logic       cfg_slope_low_i,
  input  logic       clr_wake_i,
  input  logic       clr_to_i,
  output logic       bus_drv_o,
  output logic       rxd_o,
  output logic       slope_low_o,
  output logic       stat_wake_o,
  output logic       stat_to_o
);
  logic tick;
  logic rx_s;
  logic low_pwr;
  logic wake_evt;
  logic to_fire;
  logic stat_wake_q, stat_to_q;
  logic bus_drv_q, rxd_q, slope_q;

  assign low_pwr = is_low_power(mode_i);

  lin_tick_gen #(.PRESCALE(PRESCALE)) i_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  lin_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .async_i(bus_rx_i), .sync_o(rx_s)
  );

  lin_wake_filter #(.WAKE_TICKS(WAKE_TICKS)) i_wake (
    .clk(clk), .rst(rst), .tick_i(tick),
    .enable_i(low_pwr && cfg_wake_en_i),
    .rx_i(rx_s), .wake_o(wake_evt)
  );

  lin_dom_timeout #(.TO_TICKS(TO_TICKS)) i_to (
    .clk(clk), .rst(rst), .tick_i(tick),
    .enable_i(!low_pwr && cfg_to_en_i),
    .txd_i(txd_i), .blocked_i(stat_to_q), .fire_o(to_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_wake_q <= 1'b0;
      stat_to_q   <= 1'b0;
      bus_drv_q   <= 1'b1;
      rxd_q       <= 1'b1;
      slope_q     <= 1'b0;
    end else begin
      if (wake_evt)        stat_wake_q <= 1'b1;
      else if (clr_wake_i) stat_wake_q <= 1'b0;

      if (to_fire)         stat_to_q <= 1'b1;
      else if (clr_to_i)   stat_to_q <= 1'b0;

      bus_drv_q <= low_pwr || vs_uv_i || stat_to_q || txd_i;
      rxd_q     <= low_pwr ? !stat_wake_q : rx_s;
      slope_q   <= cfg_slope_low_i;
    end
  end

  assign bus_drv_o   = bus_drv_q;
  assign rxd_o       = rxd_q;
  assign slope_low_o = slope_q;
  assign stat_wake_o = stat_wake_q;
  assign stat_to_o   = stat_to_q;
endmodule

// File: rtl/lin_phy_ctrl_chk.sv
module lin_phy_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       vs_uv_i,
  input logic       cfg_wake_en_i,
  input logic       clr_to_i,
  input logic       bus_drv_o,
  input logic       rxd_o,
  input logic       stat_wake_o,
  input logic       stat_to_o
);
  // R2
  uv_recessive_chk: assert property (@(posedge clk) disable iff (rst)
    vs_uv_i |=> bus_drv_o);

  // R3
  lowpwr_recessive_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'd0) |=> bus_drv_o);

  // R4
  wake_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_i != 2'd0) && stat_wake_o) |=> !rxd_o);

  // R7
  wake_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_wake_o) |-> ($past(mode_i) != 2'd0) && $past(cfg_wake_en_i));

  // R8
  blocked_drive_chk: assert property (@(posedge clk) disable iff (rst)
    stat_to_o |=> bus_drv_o);

  // R9
  release_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_to_o) |-> $past(clr_to_i));
endmodule

bind lin_phy_ctrl lin_phy_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .vs_uv_i(vs_uv_i),
  .cfg_wake_en_i(cfg_wake_en_i), .clr_to_i(clr_to_i),
  .bus_drv_o(bus_drv_o), .rxd_o(rxd_o),
  .stat_wake_o(stat_wake_o), .stat_to_o(stat_to_o)
);

// File: tb/test_lin_phy_ctrl.sv
module test_lin_phy_ctrl;
  localparam int P  = 3;
  localparam int WK = 5;
  localparam int TO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic txd_i = 1'b1, bus_rx_i = 1'b1, vs_uv_i = 1'b0;
  logic cfg_wake_en_i = 1'b1, cfg_to_en_i = 1'b1, cfg_slope_low_i = 1'b0;
  logic clr_wake_i = 1'b0, clr_to_i = 1'b0;
  logic bus_drv_o, rxd_o, slope_low_o, stat_wake_o, stat_to_o;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  lin_phy_ctrl #(.PRESCALE(P), .WAKE_TICKS(WK), .TO_TICKS(TO)) i_lin_phy_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_i), .txd_i(txd_i), .bus_rx_i(bus_rx_i),
    .vs_uv_i(vs_uv_i), .cfg_wake_en_i(cfg_wake_en_i), .cfg_to_en_i(cfg_to_en_i),
    .cfg_slope_low_i(cfg_slope_low_i), .clr_wake_i(clr_wake_i), .clr_to_i(clr_to_i),
    .bus_drv_o(bus_drv_o), .rxd_o(rxd_o), .slope_low_o(slope_low_o),
    .stat_wake_o(stat_wake_o), .stat_to_o(stat_to_o)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    chk("R1 reset bus_drv", bus_drv_o, 1'b1);
    chk("R1 reset rxd", rxd_o, 1'b1);
    chk("R11 reset slope", slope_low_o, 1'b0);
    chk("R4 reset wake", stat_wake_o, 1'b0);
    chk("R8 reset to", stat_to_o, 1'b0);

    // R1 pass-through sweep over txd/bus combinations
    for (int v = 0; v < 16; v++) begin
      txd_i = v[0]; bus_rx_i = v[1];
      wait_n(4);
      chk("R1 bus_drv", bus_drv_o, v[0]);
      chk("R1 rxd", rxd_o, v[1]);
    end
    txd_i = 1'b1; bus_rx_i = 1'b1; wait_n(4);

    // R2 undervoltage
    vs_uv_i = 1'b1; txd_i = 1'b0; wait_n(4);
    chk("R2 uv recessive", bus_drv_o, 1'b1);
    txd_i = 1'b1; vs_uv_i = 1'b0; wait_n(3);

    // R11 slope select
    cfg_slope_low_i = 1'b1; wait_n(2);
    chk("R11 slope low", slope_low_o, 1'b1);
    cfg_slope_low_i = 1'b0; wait_n(2);
    chk("R11 slope normal", slope_low_o, 1'b0);

    // R10 time-out disabled
    cfg_to_en_i = 1'b0; txd_i = 1'b0; wait_n(10 * P);
    chk("R10 no latch", stat_to_o, 1'b0);
    chk("R10 still dominant", bus_drv_o, 1'b0);
    txd_i = 1'b1; cfg_to_en_i = 1'b1; wait_n(3);

    // R8/R9 time-out length sweep
    for (int L = 1; L <= TO + 2; L++) begin
      txd_i = 1'b1; wait_n(3 + (L % P));
      txd_i = 1'b0; wait_n(L * P);
      chk("R8 latch vs length", stat_to_o, L >= TO);
      if (L >= TO) begin
        wait_n(2);
        chk("R8 forced recessive", bus_drv_o, 1'b1);
        txd_i = 1'b1; wait_n(3);
        txd_i = 1'b0; wait_n(2);
        chk("R9 still blocked", bus_drv_o, 1'b1);
        chk("R9 status held", stat_to_o, 1'b1);
        txd_i = 1'b1; clr_to_i = 1'b1; wait_n(1);
        clr_to_i = 1'b0; wait_n(1);
        chk("R9 cleared", stat_to_o, 1'b0);
        txd_i = 1'b0; wait_n(2);
        chk("R9 released drive", bus_drv_o, 1'b0);
        txd_i = 1'b1; wait_n(2);
      end else begin
        txd_i = 1'b1; wait_n(3);
        chk("R8 short low no latch", stat_to_o, 1'b0);
      end
    end

    // R3 low-power modes ignore txd
    for (int m = 1; m < 4; m++) begin
      mode_i = 2'(m); txd_i = 1'b0; wait_n(4);
      chk("R3 lowpwr recessive", bus_drv_o, 1'b1);
      chk("R3 lowpwr rxd high", rxd_o, 1'b1);
      txd_i = 1'b1; wait_n(1);
    end

    // R4/R5/R6 wake length sweep
    for (int L = 1; L <= WK + 2; L++) begin
      mode_i = (L % 2 == 0) ? 2'd2 : 2'd1;
      bus_rx_i = 1'b1; wait_n(4 + (L % P));
      bus_rx_i = 1'b0; wait_n(L * P);
      if (L >= WK) begin
        wait_n(10);
        chk("R6 stuck dominant no wake", stat_wake_o, 1'b0);
        chk("R6 rxd still high", rxd_o, 1'b1);
      end
      bus_rx_i = 1'b1; wait_n(5);
      chk(L >= WK ? "R4 wake accepted" : "R5 short pulse rejected", stat_wake_o, L >= WK);
      chk("R4 rxd irq", rxd_o, !(L >= WK));
      if (L >= WK) begin
        clr_wake_i = 1'b1; wait_n(1);
        clr_wake_i = 1'b0; wait_n(2);
        chk("R12 clear wake", stat_wake_o, 1'b0);
        chk("R12 rxd released", rxd_o, 1'b1);
      end
    end

    // R7 wakeup disabled
    cfg_wake_en_i = 1'b0;
    bus_rx_i = 1'b0; wait_n((WK + 3) * P);
    bus_rx_i = 1'b1; wait_n(5);
    chk("R7 disabled no wake", stat_wake_o, 1'b0);
    chk("R7 rxd high", rxd_o, 1'b1);
    cfg_wake_en_i = 1'b1;

    // R12 normal mode rxd follows bus while wake flag set
    bus_rx_i = 1'b0; wait_n((WK + 1) * P);
    bus_rx_i = 1'b1; wait_n(5);
    chk("R4 wake for R12", stat_wake_o, 1'b1);
    mode_i = 2'd0; wait_n(4);
    chk("R12 normal rxd high", rxd_o, 1'b1);
    bus_rx_i = 1'b0; wait_n(4);
    chk("R12 normal rxd follows", rxd_o, 1'b0);
    chk("R12 flag kept", stat_wake_o, 1'b1);
    bus_rx_i = 1'b1; clr_wake_i = 1'b1; wait_n(1);
    clr_wake_i = 1'b0; wait_n(2);
    chk("R12 flag cleared", stat_wake_o, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule